// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits in a single-wire automotive serial bus node between the protocol controller's transmit-data line and the enable of the bus low-side driver. A low level on the transmit line asks for a dominant bus and a high level leaves the bus recessive. The guard passes that request through to a drive-dominant output, but only while the mode controller grants transmission. The transmit line is asynchronous, so it is first resampled into the local clock domain.

Time is counted in ticks of a clock-enable input. If the synchronized transmit line requests dominant for a full timeout window without a break, the guard forces the bus recessive and enters a lockout. The lockout ends only when the transmit line has stayed high for a qualified re-arm interval. A short high blip does not release it. On entry to the lockout a sticky status flag is set, and software clears it with a write-one-to-clear strobe. With the default 1 µs tick, the timeout is 9000 ticks and the re-arm interval is 10 ticks.

Top module: `txd_dom_guard`

## Requirements
- R1: When out of reset, granted (`tx_allow`=1) and not locked out, `drive_dom` is the inverse of `txd_in`, delayed by the two-flop synchronizer. A change on `txd_in` set up before clock edge k is visible on `drive_dom` after edge k+1.
- R2: With `tx_allow`=0, `drive_dom` is 0 in the same cycle whatever `txd_in` is. Low time spent without the grant counts nothing toward the timeout, so it never causes a lockout.
- R3: A granted low that lasts `DOM_LIMIT` consecutive ticks puts the guard into lockout. With a tick on every cycle, `drive_dom` is high for exactly `DOM_LIMIT` cycles. It falls on the same edge that raises `lockout`.
- R4: A granted low shorter than `DOM_LIMIT` ticks leaves no residue. The next low again gets the full `DOM_LIMIT` window.
- R5: In lockout, `drive_dom` stays 0 even when `txd_in` is low. The lockout ends only after the synchronized `txd_in` has been high for `REARM_LIMIT` consecutive ticks. With a tick on every cycle, `lockout` falls `REARM_LIMIT`+2 edges after `txd_in` rises.
- R6: In lockout, a high interval shorter than `REARM_LIMIT` ticks restarts the re-arm count and keeps the lockout.
- R7: Both windows advance only on cycles with `tick`=1. A low held while `tick`=0 never times out.
- R8: `timeout_flag` is set on entry to lockout and stays set through the release. It is cleared by a one-cycle `stat_clr`=1. If lockout entry and `stat_clr` fall in the same cycle, the flag ends up set.
- R9: While `rst_n`=0, `drive_dom`, `lockout` and `timeout_flag` are 0 and the synchronizer holds recessive. A transmit line that stays low from reset (an undriven pin with its pull-down) is treated as a dominant request and times out per R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable, one pulse per time unit |
| txd_in | input | 1 | Asynchronous transmit data, 0 requests dominant |
| tx_allow | input | 1 | Mode controller grant; driving allowed only when 1 |
| stat_clr | input | 1 | Write-one-to-clear strobe for `timeout_flag` |
| drive_dom | output | 1 | Enable of the bus low-side driver, 1 = dominant |
| lockout | output | 1 | 1 while the bus is forced recessive after a timeout |
| timeout_flag | output | 1 | Sticky timeout status |

## Verification
Two things can land in one cycle: the status flag being set by lockout entry and the status flag being cleared by the write-one-to-clear strobe. The bench holds the transmit line low with the grant on and asserts `stat_clr` in exactly the cycle in which the last tick of the timeout window is counted. It then checks that `lockout` and `timeout_flag` are both high on the next sample. A later `stat_clr` on its own must clear the flag. Timeout and re-arm boundaries are checked one tick either side of the limit.

// File: rtl/txg_pkg.sv
package txg_pkg;

  typedef enum logic {
    GUARD_ARMED  = 1'b0,
    GUARD_LOCKED = 1'b1
  } guard_state_e;

  // Counter width for a window that counts 0 .. limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/txg_tick_timer.sv
module txg_tick_timer #(
  parameter  int unsigned LIMIT = 10,
  localparam int unsigned W     = txg_pkg::cnt_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  output logic         done,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  // The window closes on the tick that would carry the count to LIMIT.
  assign done = run && tick && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (!run || done) count <= '0;
    else if (tick)         count <= count + 1'b1;
  end

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned DOM_LIMIT   = 9000,
  parameter int unsigned REARM_LIMIT = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txd_in,
  input  logic tx_allow,
  input  logic stat_clr,
  output logic drive_dom,
  output logic lockout,
  output logic timeout_flag
);
  import txg_pkg::*;

  localparam int unsigned DOM_W = cnt_width(DOM_LIMIT);
  localparam int unsigned REL_W = cnt_width(REARM_LIMIT);

  logic             txd_s;
  guard_state_e     state, state_nx;
  logic             dom_run, rel_run;
  logic             dom_done, rel_done;
  logic [DOM_W-1:0] dom_cnt;
  logic [REL_W-1:0] rel_cnt;

  txg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(txd_in), .q(txd_s)
  );

  // Dominant time accrues only while a granted dominant request is live.
  assign dom_run = (state == GUARD_ARMED) && tx_allow && !txd_s;
  // Recessive time accrues only while locked and the line is high.
  assign rel_run = (state == GUARD_LOCKED) && txd_s;

  txg_tick_timer #(.LIMIT(DOM_LIMIT)) dom_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(dom_run), .tick(tick),
    .done(dom_done), .count(dom_cnt)
  );

  txg_tick_timer #(.LIMIT(REARM_LIMIT)) rel_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(rel_run), .tick(tick),
    .done(rel_done), .count(rel_cnt)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      GUARD_ARMED:  if (dom_done) state_nx = GUARD_LOCKED;
      GUARD_LOCKED: if (rel_done) state_nx = GUARD_ARMED;
      default:      state_nx = GUARD_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= GUARD_ARMED;
    else        state <= state_nx;
  end

  // Setting takes priority over the clear strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        timeout_flag <= 1'b0;
    else if (dom_done) timeout_flag <= 1'b1;
    else if (stat_clr) timeout_flag <= 1'b0;
  end

  assign drive_dom = dom_run;
  assign lockout   = (state == GUARD_LOCKED);

endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk #(
  parameter int unsigned DOM_LIMIT   = 9000,
  parameter int unsigned REARM_LIMIT = 10,
  localparam int unsigned DOM_W = txg_pkg::cnt_width(DOM_LIMIT),
  localparam int unsigned REL_W = txg_pkg::cnt_width(REARM_LIMIT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_allow,
  input logic             stat_clr,
  input logic             drive_dom,
  input logic             lockout,
  input logic             timeout_flag,
  input logic             dom_done,
  input logic             rel_done,
  input logic [DOM_W-1:0] dom_cnt,
  input logic [REL_W-1:0] rel_cnt
);

  localparam logic [DOM_W-1:0] DOM_LAST = DOM_W'(DOM_LIMIT - 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(REARM_LIMIT - 1);

  // R2
  no_drive_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_allow |-> !drive_dom);

  // R5
  no_drive_in_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !drive_dom);

  // R3
  lock_only_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> $past(dom_done) && ($past(dom_cnt) == DOM_LAST));

  // R5
  release_only_after_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockout) |-> $past(rel_done) && ($past(rel_cnt) == REL_LAST));

  // R8
  flag_set_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> timeout_flag);

  // R8
  flag_clear_only_by_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_flag) |-> $past(stat_clr) && !$past(dom_done));

  // R3
  dom_count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_cnt <= DOM_LAST);

  // R6
  rel_count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt <= REL_LAST);

endmodule

bind txd_dom_guard txd_dom_guard_chk #(
  .DOM_LIMIT(DOM_LIMIT), .REARM_LIMIT(REARM_LIMIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_allow(tx_allow), .stat_clr(stat_clr),
  .drive_dom(drive_dom), .lockout(lockout), .timeout_flag(timeout_flag),
  .dom_done(dom_done), .rel_done(rel_done), .dom_cnt(dom_cnt), .rel_cnt(rel_cnt)
);

// File: tb/txd_dom_guard_tb_top.sv
module txd_dom_guard_tb_top;

  localparam int unsigned L  = 24;  // dominant timeout in ticks
  localparam int unsigned R  = 5;   // re-arm interval in ticks
  localparam int unsigned WD = 20000;

  localparam int unsigned VEC_N = 7;
  localparam int unsigned V_DUR   [VEC_N] = '{1, 2, L-1, L, L+5, L+5, L/2};
  localparam bit          V_ALLOW [VEC_N] = '{1, 1, 1,   1, 1,   0,   1};

  logic clk = 1'b0;
  logic rst_n, tick, txd_in, tx_allow, stat_clr;
  logic drive_dom, lockout, timeout_flag;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  txd_dom_guard #(.DOM_LIMIT(L), .REARM_LIMIT(R), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txd_in(txd_in), .tx_allow(tx_allow),
    .stat_clr(stat_clr), .drive_dom(drive_dom), .lockout(lockout),
    .timeout_flag(timeout_flag)
  );

  task automatic tic(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic bit exp_lock(input bit allow, input int unsigned dur);
    return allow && (dur >= L);
  endfunction

  task automatic restore();
    txd_in = 1'b1; tx_allow = 1'b1; tick = 1'b1;
    tic(R + 3);
    stat_clr = 1'b1; tic(1); stat_clr = 1'b0; tic(1);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; txd_in = 1'b0; tx_allow = 1'b1; stat_clr = 1'b0;
    tic(3);
    chk("R9", "drive_dom in reset", drive_dom, 1'b0);
    chk("R9", "lockout in reset", lockout, 1'b0);
    chk("R9", "timeout_flag in reset", timeout_flag, 1'b0);

    // R9/R3: line held low from reset times out after exactly L cycles of drive.
    rst_n = 1'b1;
    tic(2);
    chk("R1", "drive after sync latency", drive_dom, 1'b1);
    tic(L - 1);
    chk("R3", "drive at last window cycle", drive_dom, 1'b1);
    chk("R3", "no lock before window end", lockout, 1'b0);
    tic(1);
    chk("R3", "drive cut at timeout", drive_dom, 1'b0);
    chk("R9", "floating low locks", lockout, 1'b1);
    chk("R8", "flag on lock entry", timeout_flag, 1'b1);
    tic(10);
    chk("R5", "low in lockout stays recessive", drive_dom, 1'b0);

    // R6: short high blip keeps the lockout.
    txd_in = 1'b1; tic(R - 1);
    txd_in = 1'b0; tic(3);
    chk("R6", "short high keeps lockout", lockout, 1'b1);
    // R5: exact re-arm edge.
    txd_in = 1'b1; tic(R + 1);
    chk("R5", "still locked one edge early", lockout, 1'b1);
    tic(1);
    chk("R5", "released after re-arm", lockout, 1'b0);
    chk("R8", "flag survives release", timeout_flag, 1'b1);
    stat_clr = 1'b1; tic(1); stat_clr = 1'b0;
    chk("R8", "flag cleared by strobe", timeout_flag, 1'b0);
    tic(2);

    // Vector table: low pulses of various lengths.
    for (int v = 0; v < VEC_N; v++) begin
      txd_in = 1'b0; tx_allow = V_ALLOW[v];
      if (V_DUR[v] >= 2) begin
        tic(2);
        chk(V_ALLOW[v] ? "R1" : "R2", "drive follows grant", drive_dom, V_ALLOW[v]);
        tic(V_DUR[v] - 2);
      end else begin
        tic(V_DUR[v]);
      end
      txd_in = 1'b1;
      tic(3);
      chk(V_DUR[v] >= L ? "R3" : "R4", "lockout after pulse", lockout,
          exp_lock(V_ALLOW[v], V_DUR[v]));
      chk("R8", "flag after pulse", timeout_flag, exp_lock(V_ALLOW[v], V_DUR[v]));
      restore();
    end

    // R4: low just short of the window, brief high, then a fresh full window.
    txd_in = 1'b0; tic(L - 1);
    txd_in = 1'b1; tic(2);
    txd_in = 1'b0; tic(L + 1);
    chk("R4", "no residue from earlier low", lockout, 1'b0);
    chk("R4", "still driving in new window", drive_dom, 1'b1);
    tic(1);
    chk("R4", "new window times out on time", lockout, 1'b1);
    restore();

    // R2: grant removal is immediate and stops the count.
    txd_in = 1'b0; tic(2);
    chk("R1", "drive with grant", drive_dom, 1'b1);
    tx_allow = 1'b0; #1;
    chk("R2", "drive drops with grant", drive_dom, 1'b0);
    tic(2 * L);
    chk("R2", "no lock without grant", lockout, 1'b0);
    tx_allow = 1'b1; #1;
    chk("R2", "drive resumes with grant", drive_dom, 1'b1);
    restore();

    // R7: no ticks, no time.
    tick = 1'b0; txd_in = 1'b0; tic(3 * L);
    chk("R7", "no lock without ticks", lockout, 1'b0);
    chk("R7", "still driving without ticks", drive_dom, 1'b1);
    tick = 1'b1; tic(L - 1);
    chk("R7", "not locked one tick early", lockout, 1'b0);
    tic(1);
    chk("R7", "locked after L ticks", lockout, 1'b1);
    restore();

    // R8: lock entry and clear strobe in the same cycle.
    txd_in = 1'b0; tic(L + 1);
    stat_clr = 1'b1; tic(1); stat_clr = 1'b0;
    chk("R8", "lock with simultaneous clear", lockout, 1'b1);
    chk("R8", "set wins over clear", timeout_flag, 1'b1);
    stat_clr = 1'b1; tic(1); stat_clr = 1'b0;
    chk("R8", "lone clear afterwards", timeout_flag, 1'b0);
    restore();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule